// File: doc/BRIEF.md
# Flash Erase Suspend and Resume Command Controller

This block is the command front end of a small block-erasable flash store. It takes one-cycle bus writes that carry command bytes and one-cycle bus reads. It runs block erases and word programs. The array and every operation time are modelled: erase, program, erase timeout window and suspend latency are each a cycle count set by a parameter. The array holds `NBLK` blocks of `WPB` words of `DW` bits, and it comes out of reset erased (all ones). A word address is laid out as `{block, word}`, with the block index in the upper bits.

An erase that is already running can be paused. While it is paused, reads and programs are served in blocks that are not being erased. The erase is then either resumed with its remaining time intact or abandoned. Reads return either array data or a status byte. In the status byte, bit 6 and bit 2 toggle from one read to the next. Which of these bits toggle depends on the addressed block and on the operation in progress, so software can tell busy, suspended and erasing blocks apart. Every other status bit reads 0.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Writing 80h and then 30h to a block address marks that block and opens a timeout window of `TO_CYC` cycles. Further 30h writes inside the window mark more blocks. The erase then runs for `ERASE_CYC` cycles, so `ready` rises `TO_CYC+ERASE_CYC` cycles after the confirming write. Every word of each marked block then reads FFh, and unmarked blocks keep their data.
- R2: While the timeout window or the erase is running, a read returns a status byte. Bit 6 inverts on every such read. Bit 2 inverts on every read of a marked block and reads 0 for other blocks. All other bits are 0.
- R3: B0h written during the timeout window or the erase is accepted. `ready` stays low for `SUSP_LAT` more cycles and then goes high, and the controller is then suspended.
- R4: B0h written when no erase is running (idle, or during a program) has no effect. A running program still ends `PROG_CYC` cycles after its data write.
- R5: While suspended, a read of a marked block returns bit 6 = 1 and bit 2 inverting on each such read, with the other bits 0. A read of any other block returns its stored word.
- R6: While suspended, any byte other than 30h, A0h or F0h is ignored: `ready` stays high and reads behave as in R5.
- R7: 30h written while suspended resumes the erase. The erase progress made before the suspend is kept, so the erase cycles before and after the suspend add up to `ERASE_CYC`. A suspend taken inside the timeout window ends the window, and the resumed erase takes the full `ERASE_CYC` cycles.
- R8: A0h followed by a data write to an address programs that word. `ready` goes low for `PROG_CYC` cycles, and the word becomes its old value AND the data. Reads during the program return bit 6 inverting, with bit 2 and the other bits 0.
- R9: While suspended, A0h and a data write to an unmarked block program that word (R8 timing and AND rule). During the program, reads show both bit 6 and bit 2 inverting. Afterwards the controller is suspended again.
- R10: While suspended, a program aimed at a marked block is rejected. No program time is spent, `ready` stays high, and reads behave as in R5.
- R11: F0h written while suspended abandons the erase and returns to idle. Each marked block is flagged invalid and reads all ones even after later programs. A later completed erase of that block clears the flag.
- R12: A read strobe with the write strobe low gives `rd_valid` and `rd_data` exactly one cycle later. A read strobe raised together with a write strobe is ignored.
- R13: After reset, `ready` is 1, `rd_valid` is 0 and every word reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | One-cycle write strobe carrying a command or program data |
| bus_re | input | 1 | One-cycle read strobe |
| bus_addr | input | AW | Word address `{block, word}` |
| bus_wdata | input | DW | Write data; the command byte is in bits 7:0 |
| rd_data | output | DW | Read result: array word or status byte |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a read result |
| ready | output | 1 | High when no timed operation is running |

## Verification
The erase is driven in four ways: run to completion without a break, paused part way through the erase and resumed, paused inside the timeout window and resumed, and paused and then abandoned. The number of cycles `ready` stays low after a resume separates a design that keeps the remaining erase count from one that restarts it or loses it. Reads during a pause alternate between marked and unmarked blocks, so the bit 6 and bit 2 patterns show which block class the design decoded. Programs are issued while idle, while suspended into an unmarked block and while suspended into a marked block, with data chosen so that the AND rule changes the stored word.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_ERS_WAIT,
        ST_ERASING,
        ST_SUS_PEND,
        ST_SUSPENDED,
        ST_SPRG_SETUP,
        ST_SPRG_RUN,
        ST_PRG_SETUP,
        ST_PRG_RUN
    } fsr_state_e;

    localparam logic [7:0] CMD_ERS_SETUP = 8'h80;
    localparam logic [7:0] CMD_ERS_GO    = 8'h30;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_RESET     = 8'hF0;

    localparam int BIT_TOG_A = 6;
    localparam int BIT_TOG_B = 2;

    // How a read is answered in a given state.
    typedef struct packed {
        logic use_array;
        logic tog_a;
        logic tog_b;
        logic hold_a;
    } rd_ctl_t;

    function automatic logic op_busy(fsr_state_e s);
        case (s)
            ST_ERS_WAIT, ST_ERASING, ST_SUS_PEND, ST_SPRG_RUN, ST_PRG_RUN: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic rd_ctl_t rd_decode(fsr_state_e s, logic marked);
        rd_ctl_t c;
        c = '0;
        case (s)
            ST_ERS_WAIT, ST_ERASING, ST_SUS_PEND: begin
                c.tog_a = 1'b1;
                c.tog_b = marked;
            end
            ST_SUSPENDED, ST_SPRG_SETUP: begin
                c.use_array = !marked;
                c.hold_a    = marked;
                c.tog_b     = marked;
            end
            ST_SPRG_RUN: begin
                c.tog_a = 1'b1;
                c.tog_b = 1'b1;
            end
            ST_PRG_RUN: c.tog_a = 1'b1;
            default: c.use_array = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fsr_cmd_fsm.sv
module fsr_cmd_fsm
    import fsr_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int WPB       = 4,
    parameter int DW        = 8,
    parameter int TO_CYC    = 8,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_LAT  = 5,
    parameter int PROG_CYC  = 6,
    localparam int BW = $clog2(NBLK),
    localparam int WW = $clog2(WPB),
    localparam int AW = BW + WW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output fsr_state_e      state_o,
    output logic [NBLK-1:0] mark_o,
    output logic            prog_go,
    output logic [AW-1:0]   prog_addr,
    output logic [DW-1:0]   prog_data,
    output logic            erase_go,
    output logic            abort_go
);

    localparam int TMAX_A = (TO_CYC > SUSP_LAT) ? TO_CYC : SUSP_LAT;
    localparam int TMAX   = (TMAX_A > PROG_CYC) ? TMAX_A : PROG_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int EW     = $clog2(ERASE_CYC + 1);

    fsr_state_e      st_q, st_d;
    logic [NBLK-1:0] mark_q, mark_d;
    logic [TW-1:0]   tmr_q, tmr_d;
    logic [EW-1:0]   rem_q, rem_d;
    logic [AW-1:0]   pa_q, pa_d;
    logic [DW-1:0]   pd_q, pd_d;

    logic [7:0]    cmd;
    logic [BW-1:0] wblk;
    logic          tmr_last;
    logic          rem_last;

    assign cmd      = wr_data[7:0];
    assign wblk     = wr_addr[AW-1:WW];
    assign tmr_last = (tmr_q == TW'(1));
    assign rem_last = (rem_q == EW'(1));

    always_comb begin
        st_d     = st_q;
        mark_d   = mark_q;
        tmr_d    = tmr_q;
        rem_d    = rem_q;
        pa_d     = pa_q;
        pd_d     = pd_q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        abort_go = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (wr_en) begin
                    if (cmd == CMD_ERS_SETUP)    st_d = ST_ERS_SETUP;
                    else if (cmd == CMD_PROGRAM) st_d = ST_PRG_SETUP;
                end
            end
            ST_ERS_SETUP: begin
                if (wr_en) begin
                    if (cmd == CMD_ERS_GO) begin
                        st_d         = ST_ERS_WAIT;
                        mark_d[wblk] = 1'b1;
                        tmr_d        = TW'(TO_CYC);
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_ERS_WAIT: begin
                if (wr_en && cmd == CMD_SUSPEND) begin
                    // Suspend inside the window ends the window; no erase progress yet.
                    st_d  = ST_SUS_PEND;
                    rem_d = EW'(ERASE_CYC);
                    tmr_d = TW'(SUSP_LAT);
                end else begin
                    if (wr_en && cmd == CMD_ERS_GO) mark_d[wblk] = 1'b1;
                    if (tmr_last) begin
                        st_d  = ST_ERASING;
                        rem_d = EW'(ERASE_CYC);
                    end else begin
                        tmr_d = tmr_q - TW'(1);
                    end
                end
            end
            ST_ERASING: begin
                if (wr_en && cmd == CMD_SUSPEND) begin
                    // The remaining count stays frozen in rem_q until resume.
                    st_d  = ST_SUS_PEND;
                    tmr_d = TW'(SUSP_LAT);
                end else if (rem_last) begin
                    erase_go = 1'b1;
                    mark_d   = '0;
                    st_d     = ST_IDLE;
                end else begin
                    rem_d = rem_q - EW'(1);
                end
            end
            ST_SUS_PEND: begin
                if (tmr_last) st_d = ST_SUSPENDED;
                else          tmr_d = tmr_q - TW'(1);
            end
            ST_SUSPENDED: begin
                if (wr_en) begin
                    if (cmd == CMD_ERS_GO) begin
                        st_d = ST_ERASING;
                    end else if (cmd == CMD_PROGRAM) begin
                        st_d = ST_SPRG_SETUP;
                    end else if (cmd == CMD_RESET) begin
                        abort_go = 1'b1;
                        mark_d   = '0;
                        st_d     = ST_IDLE;
                    end
                end
            end
            ST_SPRG_SETUP: begin
                if (wr_en) begin
                    if (mark_q[wblk]) begin
                        st_d = ST_SUSPENDED;
                    end else begin
                        st_d  = ST_SPRG_RUN;
                        pa_d  = wr_addr;
                        pd_d  = wr_data;
                        tmr_d = TW'(PROG_CYC);
                    end
                end
            end
            ST_SPRG_RUN: begin
                if (tmr_last) begin
                    prog_go = 1'b1;
                    st_d    = ST_SUSPENDED;
                end else begin
                    tmr_d = tmr_q - TW'(1);
                end
            end
            ST_PRG_SETUP: begin
                if (wr_en) begin
                    st_d  = ST_PRG_RUN;
                    pa_d  = wr_addr;
                    pd_d  = wr_data;
                    tmr_d = TW'(PROG_CYC);
                end
            end
            ST_PRG_RUN: begin
                if (tmr_last) begin
                    prog_go = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    tmr_d = tmr_q - TW'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mark_q <= '0;
            tmr_q  <= '0;
            rem_q  <= '0;
            pa_q   <= '0;
            pd_q   <= '0;
        end else begin
            st_q   <= st_d;
            mark_q <= mark_d;
            tmr_q  <= tmr_d;
            rem_q  <= rem_d;
            pa_q   <= pa_d;
            pd_q   <= pd_d;
        end
    end

    assign state_o   = st_q;
    assign mark_o    = mark_q;
    assign prog_addr = pa_q;
    assign prog_data = pd_q;

endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
    parameter int NBLK = 4,
    parameter int WPB  = 4,
    parameter int DW   = 8,
    localparam int BW = $clog2(NBLK),
    localparam int WW = $clog2(WPB),
    localparam int AW = BW + WW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_go,
    input  logic [AW-1:0]   prog_addr,
    input  logic [DW-1:0]   prog_data,
    input  logic            erase_go,
    input  logic            abort_go,
    input  logic [NBLK-1:0] mark,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_word,
    output logic            rd_inval
);

    logic [NBLK-1:0][DW-1:0] blk_rd;
    logic [NBLK-1:0]         blk_inv;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [DW-1:0] words [WPB];
        logic          inval_q;
        logic          hit_prog;

        assign hit_prog = prog_go && (prog_addr[AW-1:WW] == BW'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WPB; w++) words[w] <= '1;
                inval_q <= 1'b0;
            end else if (erase_go && mark[b]) begin
                for (int w = 0; w < WPB; w++) words[w] <= '1;
                inval_q <= 1'b0;
            end else begin
                if (abort_go && mark[b]) inval_q <= 1'b1;
                if (hit_prog) begin
                    words[prog_addr[WW-1:0]] <= words[prog_addr[WW-1:0]] & prog_data;
                end
            end
        end

        assign blk_rd[b]  = words[rd_addr[WW-1:0]];
        assign blk_inv[b] = inval_q;
    end

    assign rd_word  = blk_rd[rd_addr[AW-1:WW]];
    assign rd_inval = blk_inv[rd_addr[AW-1:WW]];

endmodule

// File: rtl/fsr_rd_port.sv
module fsr_rd_port
    import fsr_pkg::*;
#(
    parameter int NBLK = 4,
    parameter int DW   = 8,
    localparam int BW = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [BW-1:0]   rd_blk,
    input  fsr_state_e      state,
    input  logic [NBLK-1:0] mark,
    input  logic [DW-1:0]   arr_word,
    input  logic            arr_inval,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid
);

    rd_ctl_t       ctl;
    logic          take;
    logic          tga_q, tgb_q;
    logic [DW-1:0] stat;
    logic [DW-1:0] word;

    assign take = rd_en && !wr_en;
    assign ctl  = rd_decode(state, mark[rd_blk]);

    always_comb begin
        stat            = '0;
        stat[BIT_TOG_A] = ctl.hold_a | (ctl.tog_a & tga_q);
        stat[BIT_TOG_B] = ctl.tog_b & tgb_q;
        if (ctl.use_array) word = arr_inval ? '1 : arr_word;
        else               word = stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            tga_q    <= 1'b0;
            tgb_q    <= 1'b0;
        end else begin
            rd_valid <= take;
            if (take) begin
                rd_data <= word;
                if (ctl.tog_a) tga_q <= ~tga_q;
                if (ctl.tog_b) tgb_q <= ~tgb_q;
            end
        end
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import fsr_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int WPB       = 4,
    parameter int DW        = 8,
    parameter int TO_CYC    = 8,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_LAT  = 5,
    parameter int PROG_CYC  = 6,
    localparam int BW = $clog2(NBLK),
    localparam int WW = $clog2(WPB),
    localparam int AW = BW + WW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          ready
);

    fsr_state_e      st;
    logic [NBLK-1:0] mark;
    logic            prog_go, erase_go, abort_go;
    logic [AW-1:0]   prog_addr;
    logic [DW-1:0]   prog_data;
    logic [DW-1:0]   arr_word;
    logic            arr_inval;

    fsr_cmd_fsm #(
        .NBLK(NBLK), .WPB(WPB), .DW(DW), .TO_CYC(TO_CYC),
        .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT), .PROG_CYC(PROG_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .state_o(st), .mark_o(mark), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_go(erase_go), .abort_go(abort_go)
    );

    fsr_array #(.NBLK(NBLK), .WPB(WPB), .DW(DW)) u_array (
        .clk(clk), .rst(rst), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_go(erase_go), .abort_go(abort_go),
        .mark(mark), .rd_addr(bus_addr), .rd_word(arr_word), .rd_inval(arr_inval)
    );

    fsr_rd_port #(.NBLK(NBLK), .DW(DW)) u_rd (
        .clk(clk), .rst(rst), .rd_en(bus_re), .wr_en(bus_we),
        .rd_blk(bus_addr[AW-1:WW]), .state(st), .mark(mark),
        .arr_word(arr_word), .arr_inval(arr_inval),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign ready = !op_busy(st);

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] wcmd,
    input fsr_state_e st,
    input logic       ready,
    input logic       rd_valid,
    input logic       erase_go,
    input logic       abort_go,
    input logic       prog_go
);

    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_re && !bus_we) |=> rd_valid);

    assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !(bus_re && !bus_we) |=> !rd_valid);

    assert_suspend_taken_R3: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ERASING || st == ST_ERS_WAIT) && bus_we && wcmd == CMD_SUSPEND)
        |=> (st == ST_SUS_PEND && !ready));

    assert_suspend_idle_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && bus_we && wcmd == CMD_SUSPEND) |=> (st == ST_IDLE && ready));

    assert_suspended_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED && bus_we && wcmd != CMD_ERS_GO && wcmd != CMD_PROGRAM
         && wcmd != CMD_RESET) |=> (st == ST_SUSPENDED && ready));

    assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED && bus_we && wcmd == CMD_ERS_GO) |=> (st == ST_ERASING));

    assert_sprog_returns_R9: assert property (@(posedge clk) disable iff (rst)
        (prog_go && st == ST_SPRG_RUN) |=> (st == ST_SUSPENDED && ready));

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
        abort_go |=> (st == ST_IDLE && ready));

    assert_erase_done_R1: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> (st == ST_IDLE && ready));

endmodule

bind flash_erase_ctrl fsr_checker u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .wcmd(bus_wdata[7:0]),
    .st(st), .ready(ready), .rd_valid(rd_valid), .erase_go(erase_go),
    .abort_go(abort_go), .prog_go(prog_go)
);

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NBLK = 4, WPB = 4, DW = 8;
    localparam int TO_CYC = 8, ERASE_CYC = 40, SUSP_LAT = 5, PROG_CYC = 6;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    wire  [DW-1:0] rd_data;
    wire           rd_valid;
    wire           ready;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   last_wr = 0;
    logic ma = 1'b0;
    logic mb = 1'b0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic [DW-1:0] mon_e;
    string         mon_t;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_erase_ctrl #(
        .NBLK(NBLK), .WPB(WPB), .DW(DW), .TO_CYC(TO_CYC),
        .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT), .PROG_CYC(PROG_CYC)
    ) u_flash_erase_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we  = 1'b0;
        last_wr = cyc;
    endtask

    // Driver: queue the expected word, then strobe the read.
    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_re   = 1'b1;
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Status read: bit 6 / bit 2 model with its own toggle state.
    task automatic rd_st(input logic [AW-1:0] a, input bit ta, input bit tb,
                         input bit ha, input string tag);
        logic [DW-1:0] e;
        e    = '0;
        e[6] = ha | (ta & ma);
        e[2] = tb & mb;
        if (ta) ma = ~ma;
        if (tb) mb = ~mb;
        rd(a, e, tag);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        wr(a, 8'hA0);
        wr(a, d);
        wait_ready(n);
    endtask

    // Monitor: compares each returned read against the queue head.
    always @(negedge clk) begin
        if (rd_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unrequested rd_valid actual=1 expected=0");
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (rd_data !== mon_e) begin
                    n_fail++;
                    $display("FAIL %s read data actual=%0h expected=%0h", mon_t, rd_data, mon_e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 run did not end actual=%0d expected<%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int c0;
        int s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        check(ready == 1'b1, "R13 ready after reset", int'(ready), 1);
        check(rd_valid == 1'b0, "R13 rd_valid after reset", int'(rd_valid), 0);
        rd(0, 8'hFF, "R13 word 0 erased");
        rd(15, 8'hFF, "R13 word 15 erased");

        // R8 program timing and AND rule
        wr(5, 8'hA0);
        wr(5, 8'h3C);
        check(ready == 1'b0, "R8 busy during program", int'(ready), 0);
        wait_ready(n);
        check(n == PROG_CYC - 0, "R8 program duration", n, PROG_CYC);
        rd(5, 8'h3C, "R8 programmed word");
        wr(5, 8'hA0);
        wr(5, 8'h0F);
        rd_st(5, 1, 0, 0, "R8 status during program");
        rd_st(0, 1, 0, 0, "R8 status during program");
        wait_ready(n);
        rd(5, 8'h0C, "R8 AND of old and new");

        // R4 suspend with no erase running
        wr(0, 8'hB0);
        check(ready == 1'b1, "R4 B0h in idle", int'(ready), 1);
        rd(5, 8'h0C, "R4 data after idle B0h");
        wr(1, 8'hA0);
        wr(1, 8'h55);
        wr(0, 8'hB0);
        wait_ready(n);
        check(n == PROG_CYC - 1, "R4 program unaffected by B0h", n, PROG_CYC - 1);
        rd(1, 8'h55, "R4 program result");

        prog(8, 8'h5A);
        prog(12, 8'h77);
        prog(4, 8'h11);

        // R1 uninterrupted erase of block 1
        wr(0, 8'h80);
        wr(4, 8'h30);
        wait_ready(n);
        check(n == TO_CYC + ERASE_CYC, "R1 erase duration", n, TO_CYC + ERASE_CYC);
        rd(4, 8'hFF, "R1 erased word");
        rd(5, 8'hFF, "R1 erased word");
        rd(8, 8'h5A, "R1 other block kept");
        prog(4, 8'h11);

        // R2/R3/R5/R6/R10/R9/R7: erase blocks 1 and 3, suspend mid-erase
        wr(0, 8'h80);
        wr(4, 8'h30);
        c0 = last_wr;
        wr(12, 8'h30);
        rd_st(5, 1, 1, 0, "R2 status marked block");
        rd_st(8, 1, 0, 0, "R2 status unmarked block");
        rd_st(13, 1, 1, 0, "R2 status second marked block");
        rd_st(5, 1, 1, 0, "R2 status marked block again");
        while (cyc < c0 + TO_CYC + 12) @(negedge clk);
        wr(0, 8'hB0);
        s = last_wr - c0;
        wait_ready(n);
        check(n == SUSP_LAT, "R3 suspend latency", n, SUSP_LAT);
        rd_st(4, 0, 1, 1, "R5 suspended marked block");
        rd_st(12, 0, 1, 1, "R5 suspended marked block");
        rd(8, 8'h5A, "R5 suspended unmarked block");
        rd(1, 8'h55, "R5 suspended unmarked block");

        wr(0, 8'h80);
        wr(0, 8'hB0);
        wr(0, 8'h90);
        check(ready == 1'b1, "R6 other commands ignored", int'(ready), 1);
        rd(8, 8'h5A, "R6 data read still served");
        rd_st(5, 0, 1, 1, "R6 still suspended");

        wr(0, 8'hA0);
        wr(5, 8'h00);
        check(ready == 1'b1, "R10 program to marked block rejected", int'(ready), 1);
        rd(8, 8'h5A, "R10 no program running");
        rd_st(4, 0, 1, 1, "R10 still suspended");

        wr(0, 8'hA0);
        wr(8, 8'h0F);
        check(ready == 1'b0, "R9 suspended program busy", int'(ready), 0);
        rd_st(0, 1, 1, 0, "R9 both toggle bits");
        rd_st(5, 1, 1, 0, "R9 both toggle bits");
        wait_ready(n);
        check(n == PROG_CYC - 2, "R9 suspended program duration", n, PROG_CYC - 2);
        rd(8, 8'h0A, "R9 programmed during suspend");
        rd_st(5, 0, 1, 1, "R9 back to suspended");

        wr(0, 8'h30);
        wait_ready(n);
        check(n == ERASE_CYC - (s - TO_CYC - 1), "R7 remaining erase time", n,
              ERASE_CYC - (s - TO_CYC - 1));
        rd(4, 8'hFF, "R7 block 1 erased");
        rd(13, 8'hFF, "R7 block 3 erased");
        rd(8, 8'h0A, "R7 block 2 kept");

        // R7 suspend inside timeout window
        prog(0, 8'h42);
        wr(0, 8'h80);
        wr(0, 8'h30);
        wr(0, 8'hB0);
        wait_ready(n);
        check(n == SUSP_LAT, "R3 suspend in window latency", n, SUSP_LAT);
        rd_st(1, 0, 1, 1, "R5 window-suspended marked block");
        wr(0, 8'h30);
        wait_ready(n);
        check(n == ERASE_CYC, "R7 window suspend gives full erase", n, ERASE_CYC);
        rd(0, 8'hFF, "R7 block 0 erased");

        // R11 abort
        wr(0, 8'h80);
        wr(8, 8'h30);
        c0 = last_wr;
        while (cyc < c0 + TO_CYC + 5) @(negedge clk);
        wr(0, 8'hB0);
        wait_ready(n);
        wr(0, 8'hF0);
        check(ready == 1'b1, "R11 abort returns ready", int'(ready), 1);
        rd(8, 8'hFF, "R11 invalid block reads ones");
        rd(9, 8'hFF, "R11 invalid block reads ones");
        prog(8, 8'h00);
        rd(8, 8'hFF, "R11 invalid flag masks program");
        wr(0, 8'h80);
        wr(8, 8'h30);
        wait_ready(n);
        prog(8, 8'h33);
        rd(8, 8'h33, "R11 erase clears invalid flag");

        // R12 read together with write is ignored
        bus_re    = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = 0;
        bus_wdata = 8'h90;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        bus_we = 1'b0;
        check(rd_valid == 1'b0, "R12 read with write ignored", int'(rd_valid), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 every read answered", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule